// File: doc/BRIEF.md
# Rounding saturating narrow-shift vector unit

This datapath block narrows a vector of unsigned 64-bit lanes into 32-bit results. Each lane is shifted right by an immediate amount with round-to-nearest (the bit just below the cut is added back in), and the result is clamped to the unsigned 32-bit range. Each narrowed value lands in the upper (odd) 32-bit element of its lane position in a destination vector. The lower (even) elements of the destination pass through untouched, so two passes can interleave results into one register.

All lanes are computed in parallel in one cycle. A valid strobe qualifies the operands, and the result, a per-lane clamp flag vector and an error flag are registered one cycle later together with a valid flag. An immediate outside 1..32 is rejected: the error flag rises and the destination comes back unmodified. The vector width is a parameter, a multiple of 128 bits from 128 to 2048.

Top module: `rsn_vec_unit`

## Requirements
- R1: For a legal shift s (1..32), the result for source lane value x is floor(x / 2^s) plus bit s-1 of x, computed without loss of any carry.
- R2: When the R1 value exceeds 0xFFFFFFFF, the lane result is 0xFFFFFFFF.
- R3: Bit i of sat_o is 1 exactly when lane i was clamped by R2 in a legal operation, else 0.
- R4: The result for lane i appears at res_o bits [64i+63 : 64i+32].
- R5: Bits [64i+31 : 64i] of res_o equal the same bits of dst_i from the accepted operation, for every lane.
- R6: A shift of 0 or above 32 sets err_o with the output, returns dst_i unchanged on res_o and clears sat_o; a legal shift leaves err_o at 0.
- R7: valid_o is 1 in the cycle after valid_i was 1 and 0 otherwise; err_o is 1 only together with valid_o.
- R8: While valid_i is 0, res_o and sat_o keep their values whatever the other inputs do.
- R9: After reset, valid_o, err_o, res_o and sat_o are all 0.
- R10: A source near 2^64-1 whose rounding add carries past bit 63 still clamps to 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands and shift are valid this cycle |
| shift_i | input | 6 | Right shift amount, legal range 1..32 |
| src_i | input | VEC_W | Source vector, VEC_W/64 unsigned 64-bit lanes |
| dst_i | input | VEC_W | Destination vector, 32-bit elements |
| valid_o | output | 1 | Registered result is new this cycle |
| err_o | output | 1 | Accepted shift was illegal |
| res_o | output | VEC_W | Registered destination with odd elements replaced |
| sat_o | output | VEC_W/64 | Per-lane clamp flags |

## Verification
The bench builds the block with VEC_W = 256, giving four lanes, so distinct values per lane expose any misplacement of a lane result or an even element and any crosstalk between lanes. The 6-bit shift port reaches both illegal values beyond 32 and the endpoints 1 and 32, where the rounding bit sits at bit 0 and bit 31. Full-scale 64-bit sources reach the carry out of bit 63 that the rounding add produces.

// File: rtl/rsn_pkg.sv
package rsn_pkg;
  localparam int unsigned SRC_W  = 64;
  localparam int unsigned DST_W  = 32;
  localparam int unsigned SH_W   = 6;
  localparam int unsigned SH_MAX = 32;
endpackage

// File: rtl/rsn_shift_chk.sv
module rsn_shift_chk
  import rsn_pkg::*;
(
  input  logic [SH_W-1:0] sh_i,
  output logic            legal_o
);
  always_comb legal_o = (sh_i != '0) && (sh_i <= SH_W'(SH_MAX));
endmodule

// File: rtl/rsn_lane.sv
module rsn_lane
  import rsn_pkg::*;
(
  input  logic [SRC_W-1:0] src_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [DST_W-1:0] val_o,
  output logic             sat_o
);
  logic [SRC_W:0] rnd, sum, shf;

  always_comb begin
    // half-LSB of the kept part; unused when sh_i is 0 (rejected upstream)
    rnd = (sh_i == '0) ? '0 : ({{SRC_W{1'b0}}, 1'b1} << (sh_i - 1'b1));
    // one extra bit keeps the carry out of the top source bit
    sum = {1'b0, src_i} + rnd;
    shf = sum >> sh_i;
    sat_o = |shf[SRC_W:DST_W];
    val_o = sat_o ? '1 : shf[DST_W-1:0];
  end
endmodule

// File: rtl/rsn_out_reg.sv
module rsn_out_reg #(
  parameter int unsigned VEC_W = 256,
  parameter int unsigned LANES = VEC_W / 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             err_d_i,
  input  logic [VEC_W-1:0] res_d_i,
  input  logic [LANES-1:0] sat_d_i,
  output logic             valid_o,
  output logic             err_o,
  output logic [VEC_W-1:0] res_o,
  output logic [LANES-1:0] sat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      res_o   <= '0;
      sat_o   <= '0;
    end else begin
      valid_o <= en_i;
      err_o   <= en_i & err_d_i;
      if (en_i) begin
        res_o <= res_d_i;
        sat_o <= sat_d_i;
      end
    end
  end
endmodule

// File: rtl/rsn_vec_unit.sv
module rsn_vec_unit
  import rsn_pkg::*;
#(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned LANES = VEC_W / SRC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] dst_i,
  output logic             valid_o,
  output logic             err_o,
  output logic [VEC_W-1:0] res_o,
  output logic [LANES-1:0] sat_o
);
  generate
    if ((VEC_W % 128) != 0 || VEC_W < 128 || VEC_W > 2048) begin : g_bad_w
      $error("VEC_W must be a multiple of 128 in 128..2048");
    end
  endgenerate

  logic             legal;
  logic [VEC_W-1:0] res_d;
  logic [LANES-1:0] sat_d;

  rsn_shift_chk u_shchk (.sh_i(shift_i), .legal_o(legal));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DST_W-1:0] val;
    logic             sat;

    rsn_lane u_lane (
      .src_i(src_i[i*SRC_W +: SRC_W]),
      .sh_i (shift_i),
      .val_o(val),
      .sat_o(sat)
    );

    always_comb begin
      res_d[i*SRC_W +: DST_W]         = dst_i[i*SRC_W +: DST_W];
      res_d[i*SRC_W + DST_W +: DST_W] = legal ? val : dst_i[i*SRC_W + DST_W +: DST_W];
      sat_d[i]                        = legal & sat;
    end
  end

  rsn_out_reg #(.VEC_W(VEC_W), .LANES(LANES)) u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_i),
    .err_d_i(~legal),
    .res_d_i(res_d),
    .sat_d_i(sat_d),
    .valid_o(valid_o),
    .err_o  (err_o),
    .res_o  (res_o),
    .sat_o  (sat_o)
  );
endmodule

// File: rtl/rsn_chk.sv
module rsn_chk #(
  parameter int unsigned VEC_W = 256,
  localparam int unsigned LANES = VEC_W / 64
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [5:0]       shift_i,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] dst_i,
  input logic             valid_o,
  input logic             err_o,
  input logic [VEC_W-1:0] res_o,
  input logic [LANES-1:0] sat_o
);
  logic bad_sh;
  always_comb bad_sh = (shift_i == 6'd0) || (shift_i > 6'd32);

  p_valid_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !err_o));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(res_o) && $stable(sat_o)));
  p_illegal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && bad_sh) |=> (err_o && res_o == $past(dst_i) && sat_o == '0));
  p_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !bad_sh) |=> !err_o);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_even_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> (res_o[g*64 +: 32] == $past(dst_i[g*64 +: 32])));
    p_sat_clamp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sat_o[g] |-> (res_o[g*64 + 32 +: 32] == 32'hFFFF_FFFF));
  end
endmodule

bind rsn_vec_unit rsn_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .shift_i(shift_i),
  .src_i  (src_i),
  .dst_i  (dst_i),
  .valid_o(valid_o),
  .err_o  (err_o),
  .res_o  (res_o),
  .sat_o  (sat_o)
);

// File: tb/sim_rsn_vec_unit.sv
`timescale 1ns/1ps
module sim_rsn_vec_unit;
  localparam int W = 256;
  localparam int L = W / 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [5:0]   shift_i = '0;
  logic [W-1:0] src_i = '0, dst_i = '0;
  logic         valid_o, err_o;
  logic [W-1:0] res_o;
  logic [L-1:0] sat_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rsn_vec_unit #(.VEC_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .shift_i(shift_i),
    .src_i(src_i), .dst_i(dst_i), .valid_o(valid_o), .err_o(err_o),
    .res_o(res_o), .sat_o(sat_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // floor(x/2^s) plus bit s-1, then clamp
  function automatic logic [32:0] ref_lane(input logic [63:0] x, input int s);
    logic [64:0] v;
    v = {1'b0, x >> s} + 65'(x[s-1]);
    if (v > 65'h0_FFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
    return {1'b0, v[31:0]};
  endfunction

  task automatic run_op(input logic [W-1:0] s, input logic [W-1:0] d, input int sh, input string tag);
    logic [W-1:0] e_res;
    logic [L-1:0] e_sat;
    bit           bad;
    logic [32:0]  r;
    bad = (sh < 1) || (sh > 32);
    e_res = d;
    e_sat = '0;
    if (!bad) begin
      for (int i = 0; i < L; i++) begin
        r = ref_lane(s[i*64 +: 64], sh);
        e_res[i*64 + 32 +: 32] = r[31:0];
        e_sat[i] = r[32];
      end
    end
    @(negedge clk);
    src_i = s; dst_i = d; shift_i = 6'(sh); valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    chk(valid_o === 1'b1, {tag, " R7 valid"}, W'(valid_o), W'(1));
    chk(err_o === bad, {tag, " R6 err"}, W'(err_o), W'(bad));
    chk(res_o === e_res, {tag, " R1 R4 R5 res"}, res_o, e_res);
    chk(sat_o === e_sat, {tag, " R3 sat"}, W'(sat_o), W'(e_sat));
  endtask

  task automatic t_reset;
    chk(valid_o === 1'b0 && err_o === 1'b0, "R9 flags", W'({valid_o, err_o}), '0);
    chk(res_o === '0 && sat_o === '0, "R9 data", res_o, '0);
  endtask

  task automatic t_basic;
    logic [W-1:0] s = {64'h0000_0001_2345_6789, 64'h0000_0000_0000_0003,
                       64'h0123_4567_89AB_CDEF, 64'h0000_0000_8000_0000};
    logic [W-1:0] d = {64'h1111_1111_2222_2222, 64'h3333_3333_4444_4444,
                       64'h5555_5555_6666_6666, 64'h7777_7777_8888_8888};
    run_op(s, d, 4,  "basic_s4");
    run_op(s, d, 16, "basic_s16");
    run_op(s, d, 32, "basic_s32");
    run_op(s, d, 1,  "basic_s1");
  endtask

  task automatic t_round;
    // 0x18>>4 rounds up to 2, 0x17>>4 down to 1, exact halves at s=32
    logic [W-1:0] s = {64'h0000_0000_0000_0018, 64'h0000_0000_0000_0017,
                       64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF};
    run_op(s, {W{1'b1}}, 4,  "round_s4 R1");
    run_op(s, {W{1'b1}}, 32, "round_s32 R1");
  endtask

  task automatic t_sat;
    // lane 3 saturates only via round-up, lane 1 is the largest unclamped value
    logic [W-1:0] s = {64'h0000_0001_FFFF_FFFF, 64'h0000_0001_0000_0000,
                       64'h0000_0001_FFFF_FFFE, 64'h0000_0000_0000_0000};
    run_op(s, {W{1'b0}}, 1, "sat_s1 R2 R3");
    run_op({L{64'hFFFF_FFFF_0000_0000}}, '0, 1,  "sat_all R2 R3");
    run_op({L{64'hFFFF_FFFF_0000_0000}}, '0, 32, "sat_edge32 R2");
  endtask

  task automatic t_carry;
    run_op({L{64'hFFFF_FFFF_FFFF_FFFF}}, {L{64'h0BAD_F00D_CAFE_0001}}, 32, "carry_s32 R10");
    run_op({L{64'hFFFF_FFFF_FFFF_FFFF}}, {L{64'h0BAD_F00D_CAFE_0002}}, 1,  "carry_s1 R10");
  endtask

  task automatic t_illegal;
    logic [W-1:0] d = {64'hDEAD_BEEF_0000_0001, 64'hFEED_FACE_0000_0002,
                       64'hABCD_0123_0000_0003, 64'h9999_8888_0000_0004};
    run_op({L{64'hFFFF_FFFF_FFFF_FFFF}}, d, 0,  "illegal_s0 R6");
    run_op({L{64'hFFFF_FFFF_FFFF_FFFF}}, d, 33, "illegal_s33 R6");
    run_op({L{64'hFFFF_FFFF_FFFF_FFFF}}, d, 63, "illegal_s63 R6");
  endtask

  task automatic t_hold;
    logic [W-1:0] r0;
    logic [L-1:0] s0;
    run_op({L{64'h0000_0003_0000_0000}}, {L{64'h1234_5678_9ABC_DEF0}}, 1, "hold_setup");
    r0 = res_o; s0 = sat_o;
    src_i = '1; dst_i = '0; shift_i = 6'd2;
    @(negedge clk);
    chk(valid_o === 1'b0 && err_o === 1'b0, "R7 idle flags", W'({valid_o, err_o}), '0);
    chk(res_o === r0, "R8 res held", res_o, r0);
    chk(sat_o === s0, "R8 sat held", W'(sat_o), W'(s0));
    shift_i = 6'd0;
    @(negedge clk);
    chk(res_o === r0 && err_o === 1'b0, "R8 held on idle bad shift", res_o, r0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_round();
    t_sat();
    t_carry();
    t_illegal();
    t_hold();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule